// File: doc/BRIEF.md
# External-Port DMA Request/Grant Sequencer

This block sits on the host side of an external DMA channel. It runs one bus access for each request that an outside device makes on an active-low request line. The request is first brought into the clock domain through a two-flop synchronizer. Each access then drives a fixed series of signals: an active-low read or write strobe, an active-low bank select, and an address. An active-low grant strobe sits inside the read or write strobe, so the strobe falls one cycle before the grant falls and rises one cycle before the grant rises.

A two-bit mode input chooses how the access appears on the pins:
- Grant-only mode pulses just the grant. Outside logic latches or enables its data on the grant alone.
- External mode drives the grant, the strobe, the bank select and the address together.
- Paced mode drives the strobe, the bank select and the address, and never drives the grant.

The length of the grant window is set as follows:
- A programmed wait-state count lengthens it.
- A low acknowledge input extends it further in the bus modes.
- A requester that keeps its request low at the end of the window holds the access open.

An optional idle cycle can be placed after each access. The block also keeps a simple incrementing address, loaded from a base value at reset, and a count of completed transfers.

Top module: `dma_handshake_ctrl`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, all of grantN, rdN, wrN and every msN bit are high. xferCount is 0 and addrOut equals baseAddr.
- R2: A request is taken only after reqN has been seen high since reset or since the last start. A falling edge of reqN (changed between clock edges) makes the first strobe cycle appear after the third rising edge. A request held low from reset never starts an access.
- R3: With modeSel = 0 (grant-only), rdN, wrN and all msN bits stay high throughout the access, and grantN pulses.
- R4: With modeSel = 1 (external), the access drives rdN low when dirWrite = 0 and wrN low when dirWrite = 1, never both. It drives msN[bankSel] low, and grantN also pulses.
- R5: With modeSel = 2 or 3 (paced), grantN stays high, while the strobe and the bank select behave as in R4.
- R6: When the access is not stretched, grantN stays low for waitStates + 2 cycles, and the strobe stays low for waitStates + 2 cycles, beginning one cycle earlier.
- R7: In modes 1 to 3, a low ackIn after the wait states have expired holds the grant window open. An ackIn that rises in the cycle before clock edge k lets the window close at edge k. In mode 0, ackIn is ignored.
- R8: The window closes only at an edge where the synchronized request is high. A requester that releases reqN D cycles after grant falls sees a grant low time of max(waitStates + 2, D + 4).
- R9: The strobe falls exactly one cycle before grantN falls and rises exactly one cycle before grantN rises.
- R10: The address and msN stay stable from the strobe's fall until one cycle after grantN rises. At the end of that cycle, addrOut and xferCount each increment by one.
- R11: With idleEn = 1, one extra idle cycle follows each access before a new request can start. With idleEn = 0, no idle cycle is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqN | input | 1 | Asynchronous DMA request, active low |
| ackIn | input | 1 | Bus acknowledge, high = ready |
| modeSel | input | 2 | 0 grant-only, 1 external, 2/3 paced |
| dirWrite | input | 1 | 1 = write access, 0 = read access |
| bankSel | input | $clog2(BANKS) | Bank whose select line is driven |
| waitStates | input | WAIT_W | Programmed wait-state count |
| idleEn | input | 1 | Insert one idle cycle after each access |
| baseAddr | input | ADDR_W | Address loaded at reset |
| grantN | output | 1 | Grant strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| msN | output | BANKS | Bank selects, active low, one-hot-zero |
| addrOut | output | ADDR_W | Current transfer address |
| xferCount | output | CNT_W | Completed transfers |

## Verification
The assertions check the following on every cycle:
- The pins that each mode suppresses stay high: the strobes and selects in grant-only mode, and the grant in paced mode.
- The read and write strobes are never low together, and no more than one bank select is low.
- The grant nests inside the strobe in external mode.
- The address does not move while the grant is low.
- The transfer count never jumps by more than one.

Some behaviours can only be shown by the bench's scenarios, which run against a reference model:
- the exact lengths of the grant window under wait states, a late acknowledge and a stretched request;
- the three-edge start latency and the need to re-arm;
- the one-cycle shift that the idle option adds.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [1:0] {
    MODE_GRANT  = 2'd0,
    MODE_EXT    = 2'd1,
    MODE_PACED  = 2'd2,
    MODE_PACED2 = 2'd3
  } hsMode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_GRANT = 3'd2,
    PH_TRAIL = 3'd3,
    PH_HOLD  = 3'd4,
    PH_GAP   = 3'd5
  } hsPhase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch mode/direction/bank, disarm request
    logic loadWait;  // load wait-state counter
    logic decWait;   // count one wait state down
    logic strobeOn;  // read/write strobe active
    logic grantOn;   // grant active
    logic selOn;     // address phase / bank select active
    logic advance;   // access complete: bump address and count
  } hsCtrl_t;

endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqSync,
  input  logic    armed,
  input  logic    waitDone,
  input  logic    ackIn,
  input  logic    idleEn,
  input  hsMode_e curMode,
  output hsCtrl_t cs
);
  hsPhase_e phase, phaseNext;
  logic ackOk;

  assign ackOk = (curMode == MODE_GRANT) || ackIn;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    cs        = '0;
    unique case (phase)
      PH_IDLE: begin
        if (armed && !reqSync) begin
          cs.capture = 1'b1;
          phaseNext  = PH_LEAD;
        end
      end
      PH_LEAD: begin
        cs.strobeOn = 1'b1;
        cs.selOn    = 1'b1;
        cs.loadWait = 1'b1;
        phaseNext   = PH_GRANT;
      end
      PH_GRANT: begin
        cs.strobeOn = 1'b1;
        cs.grantOn  = 1'b1;
        cs.selOn    = 1'b1;
        if (waitDone && ackOk && reqSync) phaseNext = PH_TRAIL;
        else cs.decWait = !waitDone;
      end
      PH_TRAIL: begin
        cs.grantOn = 1'b1;
        cs.selOn   = 1'b1;
        phaseNext  = PH_HOLD;
      end
      PH_HOLD: begin
        cs.selOn   = 1'b1;
        cs.advance = 1'b1;
        phaseNext  = idleEn ? PH_GAP : PH_IDLE;
      end
      PH_GAP:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/dma_hs_datapath.sv
module dma_hs_datapath
  import dma_hs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAIT_W      = 4,
  parameter int BANKS       = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BANK_W     = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqN,
  input  logic [1:0]        modeSel,
  input  logic              dirWrite,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [WAIT_W-1:0] waitStates,
  input  logic [ADDR_W-1:0] baseAddr,
  input  hsCtrl_t           cs,
  output logic              reqSync,
  output logic              armed,
  output logic              waitDone,
  output hsMode_e           curMode,
  output logic              grantN,
  output logic              rdN,
  output logic              wrN,
  output logic [BANKS-1:0]  msN,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  xferCount
);
  logic              curDir;
  logic [BANK_W-1:0] curBank;
  logic [WAIT_W-1:0] waitCnt;
  logic              busMode;
  logic              grantMode;

  // reset to "requesting" so a request held through reset must rise first
  dma_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) reqSync_i (
    .clk(clk), .rst(rst), .din(reqN), .dout(reqSync)
  );

  always_ff @(posedge clk) begin
    if (rst)             armed <= 1'b0;
    else if (cs.capture) armed <= 1'b0;
    else if (reqSync)    armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curMode <= MODE_GRANT;
      curDir  <= 1'b0;
      curBank <= '0;
    end else if (cs.capture) begin
      curMode <= hsMode_e'(modeSel);
      curDir  <= dirWrite;
      curBank <= bankSel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              waitCnt <= '0;
    else if (cs.loadWait) waitCnt <= waitStates;
    else if (cs.decWait)  waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrOut   <= baseAddr;
      xferCount <= '0;
    end else if (cs.advance) begin
      addrOut   <= addrOut + 1'b1;
      xferCount <= xferCount + 1'b1;
    end
  end

  assign busMode   = (curMode != MODE_GRANT);
  assign grantMode = (curMode == MODE_GRANT) || (curMode == MODE_EXT);

  assign grantN = ~(cs.grantOn && grantMode);
  assign rdN    = ~(cs.strobeOn && busMode && !curDir);
  assign wrN    = ~(cs.strobeOn && busMode && curDir);

  for (genvar b = 0; b < BANKS; b++) begin : g_bankSel
    assign msN[b] = ~(cs.selOn && busMode && (curBank == BANK_W'(b)));
  end
endmodule

// File: rtl/dma_handshake_ctrl.sv
module dma_handshake_ctrl
  import dma_hs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAIT_W      = 4,
  parameter int BANKS       = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqN,
  input  logic                     ackIn,
  input  logic [1:0]               modeSel,
  input  logic                     dirWrite,
  input  logic [$clog2(BANKS)-1:0] bankSel,
  input  logic [WAIT_W-1:0]        waitStates,
  input  logic                     idleEn,
  input  logic [ADDR_W-1:0]        baseAddr,
  output logic                     grantN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [BANKS-1:0]         msN,
  output logic [ADDR_W-1:0]        addrOut,
  output logic [CNT_W-1:0]         xferCount
);
  hsCtrl_t cs;
  hsMode_e curMode;
  logic    reqSync;
  logic    armed;
  logic    waitDone;

  dma_hs_ctrl ctrl_i (
    .clk(clk), .rst(rst), .reqSync(reqSync), .armed(armed),
    .waitDone(waitDone), .ackIn(ackIn), .idleEn(idleEn),
    .curMode(curMode), .cs(cs)
  );

  dma_hs_datapath #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .BANKS(BANKS),
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rst(rst), .reqN(reqN), .modeSel(modeSel),
    .dirWrite(dirWrite), .bankSel(bankSel), .waitStates(waitStates),
    .baseAddr(baseAddr), .cs(cs), .reqSync(reqSync), .armed(armed),
    .waitDone(waitDone), .curMode(curMode), .grantN(grantN),
    .rdN(rdN), .wrN(wrN), .msN(msN), .addrOut(addrOut),
    .xferCount(xferCount)
  );
endmodule

// File: rtl/dma_handshake_ctrl_chk.sv
module dma_handshake_ctrl_chk
  import dma_hs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANKS  = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              grantN,
  input logic              rdN,
  input logic              wrN,
  input logic [BANKS-1:0]  msN,
  input logic [ADDR_W-1:0] addrOut,
  input logic [CNT_W-1:0]  xferCount,
  input hsMode_e           curMode
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (grantN && rdN && wrN && (&msN)));

  // R3
  grant_only_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_GRANT) |-> (rdN && wrN && (&msN)));

  // R5
  paced_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_PACED || curMode == MODE_PACED2) |-> grantN);

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN) && $onehot0(~msN));

  // R9
  grant_fall_nested_chk: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_EXT && $fell(grantN)) |-> !(rdN && wrN));

  // R9
  grant_rise_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_EXT && $rose(grantN)) |-> $past(rdN && wrN));

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!grantN && $past(!grantN)) |-> $stable(addrOut));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (xferCount == $past(xferCount)) || (xferCount == CNT_W'($past(xferCount) + 1'b1)));
endmodule

bind dma_handshake_ctrl dma_handshake_ctrl_chk #(
  .ADDR_W(ADDR_W), .BANKS(BANKS), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .grantN(grantN), .rdN(rdN), .wrN(wrN),
  .msN(msN), .addrOut(addrOut), .xferCount(xferCount), .curMode(curMode)
);

// File: tb/dma_handshake_ctrl_tb_top.sv
module dma_handshake_ctrl_tb_top;
  localparam int ADDR_W = 16;
  localparam int WAIT_W = 4;
  localparam int BANKS  = 4;
  localparam int CNT_W  = 16;
  localparam logic [ADDR_W-1:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqN = 1'b0;
  logic ackIn = 1'b1;
  logic [1:0] modeSel = 2'd1;
  logic dirWrite = 1'b0;
  logic [1:0] bankSel = 2'd0;
  logic [WAIT_W-1:0] waitStates = '0;
  logic idleEn = 1'b0;
  logic [ADDR_W-1:0] baseAddr = BASE;
  logic grantN, rdN, wrN;
  logic [BANKS-1:0] msN;
  logic [ADDR_W-1:0] addrOut;
  logic [CNT_W-1:0] xferCount;

  int nChecks = 0;
  int nFail = 0;
  int nAcc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_handshake_ctrl #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .BANKS(BANKS), .CNT_W(CNT_W)
  ) dut_i (
    .clk(clk), .rst(rst), .reqN(reqN), .ackIn(ackIn), .modeSel(modeSel),
    .dirWrite(dirWrite), .bankSel(bankSel), .waitStates(waitStates),
    .idleEn(idleEn), .baseAddr(baseAddr), .grantN(grantN), .rdN(rdN),
    .wrN(wrN), .msN(msN), .addrOut(addrOut), .xferCount(xferCount)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  bit syncQ[$];
  int mPh = 0, mW = 0, mMode = 0, mDir = 0, mBank = 0, mAddr = 0, mCnt = 0;
  bit mArmed = 0;
  bit oldSync, mStart;

  always @(posedge clk) begin
    if (rst) begin
      syncQ = {1'b0, 1'b0};
      mPh = 0; mW = 0; mMode = 0; mDir = 0; mBank = 0;
      mAddr = int'(baseAddr); mCnt = 0; mArmed = 0;
    end else begin
      oldSync = syncQ[0];
      mStart = (mPh == 0) && mArmed && !oldSync;
      case (mPh)
        0: if (mStart) begin
             mPh = 1; mMode = int'(modeSel); mDir = int'(dirWrite); mBank = int'(bankSel);
           end
        1: begin mPh = 2; mW = int'(waitStates); end
        2: if (mW == 0 && (mMode == 0 || ackIn) && oldSync) mPh = 3;
           else if (mW > 0) mW = mW - 1;
        3: mPh = 4;
        4: begin
             mAddr = (mAddr + 1) % (1 << ADDR_W);
             mCnt = (mCnt + 1) % (1 << CNT_W);
             mPh = idleEn ? 5 : 0;
           end
        default: mPh = 0;
      endcase
      if (mStart) mArmed = 0;
      else if (oldSync) mArmed = 1;
      void'(syncQ.pop_front());
      syncQ.push_back(reqN);
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit strobeOn, grantOn, selOn, bus;
      logic [BANKS-1:0] expMs;
      strobeOn = (mPh == 1 || mPh == 2);
      grantOn  = (mPh == 2 || mPh == 3);
      selOn    = (mPh >= 1 && mPh <= 4);
      bus      = (mMode != 0);
      expMs    = '1;
      if (selOn && bus) expMs[mBank] = 1'b0;
      chk("R6", "model grantN", grantN, !(grantOn && mMode < 2));
      chk("R4", "model rdN", rdN, !(strobeOn && bus && mDir == 0));
      chk("R4", "model wrN", wrN, !(strobeOn && bus && mDir == 1));
      chk("R10", "model msN", msN, expMs);
      chk("R10", "model addrOut", addrOut, mAddr);
      chk("R10", "model xferCount", xferCount, mCnt);
    end
  end

  // ---------------- directed scenarios ----------------
  task automatic waitGrantLow(input string req);
    int n = 0;
    while (grantN && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(req, "grant seen", grantN, 0);
  endtask

  // called at the negedge where grant was first seen low
  task automatic measGrant(input int relAt, input int ackAt, output int len,
                           output bit strobeSeen, output bit p1, output bit p2);
    len = 1; strobeSeen = 0; p1 = 0; p2 = 0;
    if (relAt == 1) reqN = 1'b1;
    if (ackAt == 1) ackIn = 1'b1;
    p1 = rdN && wrN;
    if (!rdN || !wrN || !(&msN)) strobeSeen = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (grantN) break;
      len++;
      if (len == relAt) reqN = 1'b1;
      if (len == ackAt) ackIn = 1'b1;
      p2 = p1;
      p1 = rdN && wrN;
      if (!rdN || !wrN || !(&msN)) strobeSeen = 1;
    end
  endtask

  // called at the negedge where grant has just risen
  task automatic closeAccess(input string req, input int bank, input bit bus);
    if (bus) chk(req, "select held after grant", msN[bank], 0);
    chk(req, "address held after grant", addrOut, BASE + nAcc);
    @(negedge clk);
    nAcc++;
    chk(req, "address advanced", addrOut, BASE + nAcc);
    chk(req, "count advanced", xferCount, nAcc);
    chk(req, "select released", msN, {BANKS{1'b1}});
  endtask

  initial begin
    int len;
    bit sSeen, p1, p2;
    int n;
    bit seenHigh;
    bit grantSeen;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1", "grantN after reset", grantN, 1);
    chk("R1", "rdN/wrN after reset", {rdN, wrN}, 2'b11);
    chk("R1", "msN after reset", msN, {BANKS{1'b1}});
    chk("R1", "count after reset", xferCount, 0);
    chk("R1", "address after reset", addrOut, BASE);

    // R2: request held low since reset must not start
    repeat (10) @(negedge clk);
    chk("R2", "no start without re-arm", {grantN, rdN, wrN}, 3'b111);
    chk("R2", "no count without re-arm", xferCount, 0);
    reqN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 latency, R9 nesting, R6 length: external read, bank 2, W=3
    modeSel = 2'd1; dirWrite = 1'b0; bankSel = 2'd2; waitStates = 4'd3;
    reqN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "strobe not yet low", rdN, 1);
    @(negedge clk);
    chk("R2", "strobe low at third edge", rdN, 0);
    chk("R4", "bank 2 selected", msN, 4'b1011);
    chk("R9", "grant still high during lead", grantN, 1);
    @(negedge clk);
    chk("R9", "grant falls one cycle after strobe", grantN, 0);
    measGrant(1, 0, len, sSeen, p1, p2);
    chk("R6", "grant low length W=3", len, 5);
    chk("R9", "strobe high in last grant cycle", p1, 1);
    chk("R9", "strobe low one cycle earlier", p2, 0);
    closeAccess("R10", 2, 1);
    repeat (4) @(negedge clk);

    // R6: external write, W=6
    modeSel = 2'd1; dirWrite = 1'b1; bankSel = 2'd0; waitStates = 4'd6;
    reqN = 1'b0;
    waitGrantLow("R6");
    chk("R4", "write strobe during grant", {rdN, wrN}, 2'b10);
    measGrant(1, 0, len, sSeen, p1, p2);
    chk("R6", "grant low length W=6", len, 8);
    closeAccess("R10", 0, 1);
    repeat (4) @(negedge clk);

    // R3 + R7: grant-only mode, ack low is ignored
    modeSel = 2'd0; waitStates = 4'd2; ackIn = 1'b0;
    reqN = 1'b0;
    waitGrantLow("R3");
    measGrant(1, 0, len, sSeen, p1, p2);
    chk("R7", "ack ignored in grant-only mode", len, 4);
    chk("R3", "no strobe or select in grant-only", sSeen, 0);
    closeAccess("R3", 0, 0);
    ackIn = 1'b1;
    repeat (4) @(negedge clk);

    // R7: external read, late acknowledge
    modeSel = 2'd1; dirWrite = 1'b0; bankSel = 2'd1; waitStates = 4'd2; ackIn = 1'b0;
    reqN = 1'b0;
    waitGrantLow("R7");
    measGrant(1, 8, len, sSeen, p1, p2);
    chk("R7", "late ack extends grant", len, 9);
    closeAccess("R7", 1, 1);
    repeat (4) @(negedge clk);

    // R8: request held low stretches the access
    modeSel = 2'd1; dirWrite = 1'b1; bankSel = 2'd1; waitStates = 4'd1;
    reqN = 1'b0;
    waitGrantLow("R8");
    measGrant(7, 0, len, sSeen, p1, p2);
    chk("R8", "held request stretches grant", len, 10);
    closeAccess("R8", 1, 1);
    repeat (4) @(negedge clk);

    // R5: paced write, bank 3, no grant
    modeSel = 2'd2; dirWrite = 1'b1; bankSel = 2'd3; waitStates = 4'd2;
    reqN = 1'b0;
    n = 0;
    while (wrN && n < 30) begin @(negedge clk); n++; end
    chk("R5", "paced write strobe seen", wrN, 0);
    reqN = 1'b1;
    len = 1; grantSeen = 0;
    for (int i = 0; i < 40; i++) begin
      if (!grantN) grantSeen = 1;
      chk("R5", "bank 3 selected with strobe", msN, 4'b0111);
      @(negedge clk);
      if (wrN) break;
      len++;
    end
    chk("R5", "paced strobe length W=2", len, 4);
    chk("R5", "grant never low in paced", grantSeen, 0);
    repeat (2) @(negedge clk);
    nAcc++;
    chk("R10", "paced access counted", xferCount, nAcc);
    repeat (4) @(negedge clk);

    // R11: back-to-back with and without the idle cycle
    for (int pass = 0; pass < 2; pass++) begin
      modeSel = 2'd1; dirWrite = 1'b0; bankSel = 2'd0; waitStates = 4'd0;
      idleEn = (pass == 1);
      reqN = 1'b0;
      waitGrantLow("R11");
      reqN = 1'b1;
      @(negedge clk);
      reqN = 1'b0;
      n = 1; seenHigh = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        n++;
        if (rdN) seenHigh = 1;
        else if (seenHigh) break;
      end
      chk("R11", pass ? "restart spacing with idle" : "restart spacing no idle",
          n, pass ? 7 : 6);
      nAcc++;
      waitGrantLow("R11");
      reqN = 1'b1;
      n = 0;
      while (!grantN && n < 30) begin @(negedge clk); n++; end
      @(negedge clk);
      nAcc++;
      chk("R10", "back-to-back count", xferCount, nAcc);
      idleEn = 1'b0;
      repeat (5) @(negedge clk);
    end

    chk("R10", "final count", xferCount, nAcc);
    chk("R10", "final address", addrOut, BASE + nAcc);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule